// File: doc/BRIEF.md
# System Bus Address Decoder

This block is the combinational glue between a single 32-bit bus master and four slaves: a main RAM, a boot ROM and two peripheral devices. From the master's enable and address it raises at most one select line, hands each slave the low address bits it needs as a local address, and returns the selected slave's wait flag and read data to the master. The write strobe and write data are broadcast to every slave. The 2-bit transfer size is broadcast to the two memories.

The address map is fixed by parameters:

- RAM occupies the bottom 32 MB.
- ROM occupies 2 MB from 0x2000_0000.
- Peripherals live in the window from 0x3000_0000 to 0x3FFF_FFFF. That window is cut into 1 MB slots, and slot n belongs to device n.

An access that matches nothing sees a wait flag held at 1 and read data of zero. There is no error signal, so a master that touches an unmapped address stalls.

Top module: `sysbus_decoder`

## Requirements
- R1: `ram_sel` is 1 exactly when `bm_en` is 1 and `bm_addr[31:25]` is zero (addresses 0x0000_0000 to 0x01FF_FFFF).
- R2: `rom_sel` is 1 exactly when `bm_en` is 1 and `bm_addr[31:21]` equals 11'b001_0000_0000 (addresses 0x2000_0000 to 0x201F_FFFF).
- R3: Bit n of `io_sel` is 1 exactly when `bm_en` is 1, `bm_addr[31:28]` is 4'b0011 and `bm_addr[27:20]` equals n. Every other 1 MB slot of that window selects nothing.
- R4: With `bm_en` at 0 every select output is 0. At no time is more than one of `ram_sel`, `rom_sel`, `io_sel[1]`, `io_sel[0]` high.
- R5: While a slave is selected, `bm_wait` and `bm_rdata` equal that slave's wait and read data. The sources are tried in the order RAM, ROM, device 0, device 1. `io_rdata` packs device n in bits [32n+31:32n].
- R6: While no slave is selected, including whenever `bm_en` is 0, `bm_wait` is 1 and `bm_rdata` is zero.
- R7: `sl_we` and `sl_wdata` follow `bm_we` and `bm_wdata` unchanged for every address. `mem_size` follows `bm_size` unchanged.
- R8: `ram_laddr` carries `bm_addr[24:0]`, `rom_laddr` carries `bm_addr[20:0]` and `io_laddr` carries `bm_addr[19:0]`, whatever is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bm_en | input | 1 | Master transfer enable |
| bm_we | input | 1 | Master write strobe |
| bm_size | input | 2 | Master transfer size code |
| bm_addr | input | 32 | Master physical address |
| bm_wdata | input | 32 | Master write data |
| bm_rdata | output | 32 | Read data returned to master |
| bm_wait | output | 1 | Wait flag returned to master |
| sl_we | output | 1 | Write strobe broadcast to all slaves |
| sl_wdata | output | 32 | Write data broadcast to all slaves |
| mem_size | output | 2 | Transfer size for RAM and ROM |
| ram_sel | output | 1 | RAM select |
| ram_laddr | output | 25 | RAM local address |
| ram_rdata | input | 32 | RAM read data |
| ram_wait | input | 1 | RAM wait flag |
| rom_sel | output | 1 | ROM select |
| rom_laddr | output | 21 | ROM local address |
| rom_rdata | input | 32 | ROM read data |
| rom_wait | input | 1 | ROM wait flag |
| io_sel | output | 2 | Per-device select, bit n for device n |
| io_laddr | output | 20 | Device local address |
| io_rdata | input | 64 | Device read data, device n in bits [32n+31:32n] |
| io_wait | input | 2 | Device wait flags, bit n for device n |

## Verification
The bench builds the block with its default parameters: two device slots, a 32 MB RAM region, a 2 MB ROM region and 1 MB slots in the peripheral window. At these sizes every region's first and last word lies at an address the bench can write out directly. So can the first address past each region and the unused slots 2 to 255 of the window.

The slaves answer with distinct data words and mixed wait values. Any select error therefore shows up as a wrong response word.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 2;

    // Response returned to the master
    typedef struct packed {
        logic              hold;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    // True when addr lies in the aligned region of 2**lsb bytes at base
    function automatic logic region_hit(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base,
                                        input int unsigned lsb);
        return (addr >> lsb) == (base >> lsb);
    endfunction
endpackage

// File: rtl/sysbus_region_decode.sv
module sysbus_region_decode
    import sysbus_pkg::*;
#(
    parameter int               N_DEV    = 2,
    parameter logic [ADDR_W-1:0] RAM_BASE = '0,
    parameter int               RAM_LSB  = 25,
    parameter logic [ADDR_W-1:0] ROM_BASE = 32'h2000_0000,
    parameter int               ROM_LSB  = 21,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'h3000_0000,
    parameter int               IO_LSB   = 28,
    parameter int               SLOT_LSB = 20
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic [N_DEV-1:0]  dev_sel
);
    localparam int SLOT_W = IO_LSB - SLOT_LSB;
    localparam logic [ADDR_W:0] RAM_SPAN  = (ADDR_W+1)'(1) << RAM_LSB;
    localparam logic [ADDR_W:0] ROM_SPAN  = (ADDR_W+1)'(1) << ROM_LSB;
    localparam logic [ADDR_W:0] SLOT_SPAN = (ADDR_W+1)'(1) << SLOT_LSB;

    typedef struct packed {
        logic             ram;
        logic             rom;
        logic [N_DEV-1:0] dev;
    } sel_t;

    sel_t              sel_d;
    logic              io_win_d;
    logic [SLOT_W-1:0] slot_d;

    always_comb begin
        sel_d    = '0;
        io_win_d = en && region_hit(addr, IO_BASE, IO_LSB);
        slot_d   = addr[IO_LSB-1:SLOT_LSB];
        sel_d.ram = en && region_hit(addr, RAM_BASE, RAM_LSB);
        sel_d.rom = en && region_hit(addr, ROM_BASE, ROM_LSB);
        for (int i = 0; i < N_DEV; i++) begin
            sel_d.dev[i] = io_win_d && (slot_d == SLOT_W'(i));
        end

        // Assertions: selects checked against address offsets
        assert_ram_range_R1: assert (!sel_d.ram ||
            (({1'b0, addr} - {1'b0, RAM_BASE}) < RAM_SPAN));
        assert_rom_range_R2: assert (!sel_d.rom ||
            (({1'b0, addr} - {1'b0, ROM_BASE}) < ROM_SPAN));
        for (int i = 0; i < N_DEV; i++) begin
            assert_dev_slot_R3: assert (!sel_d.dev[i] ||
                (({1'b0, addr} - {1'b0, IO_BASE} - (SLOT_SPAN * i)) < SLOT_SPAN));
        end
        assert_idle_quiet_R4: assert (en || (sel_d == '0));
        assert_one_select_R4: assert ($onehot0(sel_d));
    end

    assign ram_sel = sel_d.ram;
    assign rom_sel = sel_d.rom;
    assign dev_sel = sel_d.dev;
endmodule

// File: rtl/sysbus_resp_mux.sv
module sysbus_resp_mux
    import sysbus_pkg::*;
#(
    parameter int N_DEV = 2
) (
    input  logic                    ram_sel,
    input  logic                    rom_sel,
    input  logic [N_DEV-1:0]        dev_sel,
    input  logic                    ram_hold,
    input  logic [DATA_W-1:0]       ram_rdata,
    input  logic                    rom_hold,
    input  logic [DATA_W-1:0]       rom_rdata,
    input  logic [N_DEV-1:0]        dev_hold,
    input  logic [N_DEV*DATA_W-1:0] dev_rdata,
    output logic                    m_hold,
    output logic [DATA_W-1:0]       m_rdata
);
    resp_t resp_d;

    always_comb begin
        // Unmapped: stall with zero data
        resp_d.hold  = 1'b1;
        resp_d.rdata = '0;
        // Lowest priority first so later sources override
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (dev_sel[i]) begin
                resp_d.hold  = dev_hold[i];
                resp_d.rdata = dev_rdata[i*DATA_W +: DATA_W];
            end
        end
        if (rom_sel) begin
            resp_d.hold  = rom_hold;
            resp_d.rdata = rom_rdata;
        end
        if (ram_sel) begin
            resp_d.hold  = ram_hold;
            resp_d.rdata = ram_rdata;
        end

        assert_mux_onehot_R4: assert ($onehot0({ram_sel, rom_sel, dev_sel}));
    end

    assign m_hold  = resp_d.hold;
    assign m_rdata = resp_d.rdata;
endmodule

// File: rtl/sysbus_decoder.sv
module sysbus_decoder
    import sysbus_pkg::*;
#(
    parameter int N_DEV    = 2,
    parameter int RAM_LSB  = 25,
    parameter int ROM_LSB  = 21,
    parameter int SLOT_LSB = 20
) (
    input  logic                    bm_en,
    input  logic                    bm_we,
    input  logic [SIZE_W-1:0]       bm_size,
    input  logic [ADDR_W-1:0]       bm_addr,
    input  logic [DATA_W-1:0]       bm_wdata,
    output logic [DATA_W-1:0]       bm_rdata,
    output logic                    bm_wait,
    output logic                    sl_we,
    output logic [DATA_W-1:0]       sl_wdata,
    output logic [SIZE_W-1:0]       mem_size,
    output logic                    ram_sel,
    output logic [RAM_LSB-1:0]      ram_laddr,
    input  logic [DATA_W-1:0]       ram_rdata,
    input  logic                    ram_wait,
    output logic                    rom_sel,
    output logic [ROM_LSB-1:0]      rom_laddr,
    input  logic [DATA_W-1:0]       rom_rdata,
    input  logic                    rom_wait,
    output logic [N_DEV-1:0]        io_sel,
    output logic [SLOT_LSB-1:0]     io_laddr,
    input  logic [N_DEV*DATA_W-1:0] io_rdata,
    input  logic [N_DEV-1:0]        io_wait
);
    sysbus_region_decode #(
        .N_DEV    (N_DEV),
        .RAM_BASE (32'h0000_0000),
        .RAM_LSB  (RAM_LSB),
        .ROM_BASE (32'h2000_0000),
        .ROM_LSB  (ROM_LSB),
        .IO_BASE  (32'h3000_0000),
        .IO_LSB   (28),
        .SLOT_LSB (SLOT_LSB)
    ) u_decode (
        .en      (bm_en),
        .addr    (bm_addr),
        .ram_sel (ram_sel),
        .rom_sel (rom_sel),
        .dev_sel (io_sel)
    );

    sysbus_resp_mux #(
        .N_DEV (N_DEV)
    ) u_resp (
        .ram_sel   (ram_sel),
        .rom_sel   (rom_sel),
        .dev_sel   (io_sel),
        .ram_hold  (ram_wait),
        .ram_rdata (ram_rdata),
        .rom_hold  (rom_wait),
        .rom_rdata (rom_rdata),
        .dev_hold  (io_wait),
        .dev_rdata (io_rdata),
        .m_hold    (bm_wait),
        .m_rdata   (bm_rdata)
    );

    // Broadcast signals and local addresses
    assign sl_we     = bm_we;
    assign sl_wdata  = bm_wdata;
    assign mem_size  = bm_size;
    assign ram_laddr = bm_addr[RAM_LSB-1:0];
    assign rom_laddr = bm_addr[ROM_LSB-1:0];
    assign io_laddr  = bm_addr[SLOT_LSB-1:0];
endmodule

// File: tb/sysbus_decoder_bench.sv
module sysbus_decoder_bench;
    logic        bm_en, bm_we;
    logic [1:0]  bm_size;
    logic [31:0] bm_addr, bm_wdata, bm_rdata;
    logic        bm_wait, sl_we;
    logic [31:0] sl_wdata;
    logic [1:0]  mem_size;
    logic        ram_sel, rom_sel;
    logic [24:0] ram_laddr;
    logic [20:0] rom_laddr;
    logic [1:0]  io_sel;
    logic [19:0] io_laddr;
    logic [31:0] ram_rdata, rom_rdata;
    logic        ram_wait, rom_wait;
    logic [63:0] io_rdata;
    logic [1:0]  io_wait;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;

    sysbus_decoder u_sysbus_decoder (
        .bm_en(bm_en), .bm_we(bm_we), .bm_size(bm_size), .bm_addr(bm_addr),
        .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .bm_wait(bm_wait),
        .sl_we(sl_we), .sl_wdata(sl_wdata), .mem_size(mem_size),
        .ram_sel(ram_sel), .ram_laddr(ram_laddr), .ram_rdata(ram_rdata), .ram_wait(ram_wait),
        .rom_sel(rom_sel), .rom_laddr(rom_laddr), .rom_rdata(rom_rdata), .rom_wait(rom_wait),
        .io_sel(io_sel), .io_laddr(io_laddr), .io_rdata(io_rdata), .io_wait(io_wait)
    );

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // {en, addr, expected selects {ram, rom, dev1, dev0}}
    localparam int NV = 16;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 32'h0000_0000, 4'b1000},
        {1'b1, 32'h01FF_FFFC, 4'b1000},
        {1'b1, 32'h0200_0000, 4'b0000},
        {1'b1, 32'h2000_0000, 4'b0100},
        {1'b1, 32'h201F_FFFC, 4'b0100},
        {1'b1, 32'h2020_0000, 4'b0000},
        {1'b1, 32'h3000_0000, 4'b0001},
        {1'b1, 32'h300F_FFFC, 4'b0001},
        {1'b1, 32'h3010_0000, 4'b0010},
        {1'b1, 32'h3020_0000, 4'b0000},
        {1'b1, 32'h3FF0_0000, 4'b0000},
        {1'b1, 32'h4000_0000, 4'b0000},
        {1'b1, 32'hF000_0000, 4'b0000},
        {1'b0, 32'h0000_0000, 4'b0000},
        {1'b0, 32'h3000_0000, 4'b0000},
        {1'b0, 32'h2000_0000, 4'b0000}
    };

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 64'd1, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bm_en = 0; bm_we = 0; bm_size = 2'b00; bm_addr = '0; bm_wdata = '0;
        ram_rdata = 32'hAAAA_0001; ram_wait = 1'b0;
        rom_rdata = 32'hBBBB_0002; rom_wait = 1'b1;
        io_rdata  = {32'hDDDD_0004, 32'hCCCC_0003};
        io_wait   = 2'b10;

        // Idle state
        @(negedge clk);
        check({ram_sel, rom_sel, io_sel} == 4'b0, "R4 idle selects", {ram_sel, rom_sel, io_sel}, 0);
        check(bm_wait == 1'b1 && bm_rdata == 0, "R6 idle response", {bm_wait, bm_rdata}, {1'b1, 32'h0});

        for (int v = 0; v < NV; v++) begin
            logic [3:0]  es;
            logic        ew;
            logic [31:0] ed;
            string       tag;
            @(posedge clk);
            bm_en   = VEC[v][36];
            bm_addr = VEC[v][35:4];
            es      = VEC[v][3:0];
            case (es)
                4'b1000: begin ew = ram_wait;   ed = ram_rdata;      tag = "R1"; end
                4'b0100: begin ew = rom_wait;   ed = rom_rdata;      tag = "R2"; end
                4'b0001: begin ew = io_wait[0]; ed = io_rdata[31:0];  tag = "R3"; end
                4'b0010: begin ew = io_wait[1]; ed = io_rdata[63:32]; tag = "R3"; end
                default: begin ew = 1'b1;       ed = '0;              tag = bm_en ? "R3" : "R4"; end
            endcase
            @(negedge clk);
            check({ram_sel, rom_sel, io_sel} == es, $sformatf("%s select @%h", tag, bm_addr),
                  {ram_sel, rom_sel, io_sel}, es);
            check(bm_wait == ew && bm_rdata == ed,
                  $sformatf("%s response @%h", (es == 0) ? "R6" : "R5", bm_addr),
                  {bm_wait, bm_rdata}, {ew, ed});
            check(ram_laddr == bm_addr[24:0] && rom_laddr == bm_addr[20:0] && io_laddr == bm_addr[19:0],
                  "R8 local address", {ram_laddr, rom_laddr, io_laddr}, {bm_addr[24:0], bm_addr[20:0], bm_addr[19:0]});
        end

        // R5: wait change on selected RAM reaches master
        @(posedge clk);
        bm_en = 1; bm_addr = 32'h0000_1000; ram_wait = 1'b1; ram_rdata = 32'h1234_5678;
        @(negedge clk);
        check(bm_wait == 1'b1 && bm_rdata == 32'h1234_5678, "R5 ram wait high",
              {bm_wait, bm_rdata}, {1'b1, 32'h1234_5678});
        @(posedge clk);
        ram_wait = 1'b0;
        @(negedge clk);
        check(bm_wait == 1'b0, "R5 ram wait low", bm_wait, 0);

        // R7: broadcast with device selected and while unmapped
        @(posedge clk);
        bm_addr = 32'h3010_0040; bm_we = 1; bm_size = 2'b10; bm_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        check(sl_we == 1'b1 && sl_wdata == 32'hCAFE_F00D && mem_size == 2'b10, "R7 broadcast on device",
              {sl_we, sl_wdata, mem_size}, {1'b1, 32'hCAFE_F00D, 2'b10});
        @(posedge clk);
        bm_en = 0; bm_addr = 32'h5000_0000; bm_we = 0; bm_size = 2'b01; bm_wdata = 32'h0BAD_BEEF;
        @(negedge clk);
        check(sl_we == 1'b0 && sl_wdata == 32'h0BAD_BEEF && mem_size == 2'b01, "R7 broadcast idle",
              {sl_we, sl_wdata, mem_size}, {1'b0, 32'h0BAD_BEEF, 2'b01});

        // R3: device 1 with its wait low
        @(posedge clk);
        bm_en = 1; bm_addr = 32'h301F_FFFC; io_wait = 2'b00;
        @(negedge clk);
        check(io_sel == 2'b10 && bm_wait == 1'b0 && bm_rdata == 32'hDDDD_0004, "R3 device 1 last word",
              {io_sel, bm_wait, bm_rdata}, {2'b10, 1'b0, 32'hDDDD_0004});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule